// File: doc/BRIEF.md
# SPI Status Flag and Data Buffer Controller

This block is the register-side control logic of an 8-bit SPI peripheral. It owns the transmit holding register, the receive holding register and three status flags: receive-full, transmit-empty and mode-fault. A simple CPU bus reads and writes a control register, a status register and a data register. A separate shift engine, not part of this block, reports three events: a finished byte, the pickup of the transmit byte, and a detected mode fault.

Each flag clears only through a two-step handshake. First a status read must observe the flag set. Then a specific access must follow: a data read for receive-full, a data write for transmit-empty, or a control write for mode-fault. A data write made without that handshake is discarded. When a second byte completes while receive-full is still pending, the new byte is dropped and the older one is kept. The flags are merged into one interrupt request through two enables. Clearing the enable bit returns every flag to its reset state and tells the engine to halt.

Top module: `spi_flag_ctrl`

## Requirements
- R1: An `eng_done` pulse while enabled and while receive-full is clear copies `eng_rx_byte` into the receive register and sets receive-full. Receive-full clears only when a data read follows a status read that returned it set. Any other access leaves it set.
- R2: Transmit-empty resets to 1. A data write is accepted only if an earlier status read returned transmit-empty set. An accepted write loads `tx_byte`, raises `tx_valid` and clears transmit-empty. A data write made without that handshake changes neither `tx_byte` nor `tx_valid`.
- R3: An `eng_take` pulse while `tx_valid` is high sets transmit-empty again and drops `tx_valid`. `tx_valid` is always the inverse of transmit-empty.
- R4: An `eng_fault` pulse while enabled sets mode-fault. Mode-fault clears only when a control write follows a status read that returned it set.
- R5: If receive-full is still set when `eng_done` arrives, the new byte is dropped. The receive register keeps the earlier byte and the flag stays set.
- R6: The status register is at address 1. Bit 7 is receive-full, bit 5 is transmit-empty, bit 4 is mode-fault, and every other bit reads 0. The reset value is 0x20. Writes to it have no effect.
- R7: `irq` = enable AND (((receive-full OR mode-fault) AND control bit 1) OR (transmit-empty AND control bit 2)).
- R8: The control register is at address 0. Bit 0 is the enable, and `eng_halt` is its inverse. While the enable is 0, all three flags are held at their reset state (status 0x20) on the clock edge after the bit clears. Engine pulses are then ignored and `irq` is low. The data registers keep their contents.
- R9: After reset, the control register and the data register (address 2) read 0. Control bits 7..3, address 3 and all addresses at or above 4 read 0. Writes to those bits and addresses have no effect. A cycle with both `bus_rd` and `bus_wr` high acts as a write only.
- R10: If a flag's set event (`eng_done`, `eng_fault`) arrives in the same cycle as its qualifying clearing access, the flag stays set. That access still uses up the handshake, so a new status read is needed.
- R11: A status read arms a flag's handshake only if it returns that flag set. A status read taken while the flag was clear does not permit a later clearing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| eng_done | input | 1 | Engine finished a byte |
| eng_rx_byte | input | DATA_W | Byte received by the engine, valid with eng_done |
| eng_take | input | 1 | Engine loaded the transmit byte into its shifter |
| eng_fault | input | 1 | Engine detected a mode fault |
| tx_byte | output | DATA_W | Transmit holding register |
| tx_valid | output | 1 | Transmit holding register holds an unsent byte |
| eng_halt | output | 1 | Forces the engine to idle while the block is disabled |
| irq | output | 1 | Combined interrupt request |

## Verification
A handshake bit left armed when it should not be shows up at the ports at once. The next data read or write changes the status byte, `tx_valid` or `tx_byte` in the cycle after the access. A handshake bit that fails to arm shows the opposite: a flag that survives the second access of a proper sequence. A lost overrun guard shows up on the next data read as the newer byte. A wrong interrupt gate or a flag that misses the disable reset is visible on `irq` and the status read within one cycle of the cause. The bench runs a bus-level model alongside the design. It compares every read, `irq`, `tx_valid`, `tx_byte` and `eng_halt` on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    // Flag indices
    localparam int NUM_FLAGS = 3;
    localparam int FI_RXF    = 0;   // receive-full
    localparam int FI_TXE    = 1;   // transmit-empty
    localparam int FI_MDF    = 2;   // mode-fault

    // Register selector (low two address bits)
    typedef enum logic [1:0] {
        RS_CTRL = 2'd0,
        RS_STAT = 2'd1,
        RS_DATA = 2'd2,
        RS_RSVD = 2'd3
    } reg_sel_e;

    // Control register: bit0 enable, bit1 receive/fault irq enable, bit2 transmit irq enable
    localparam int CTL_W = 3;
    typedef struct packed {
        logic tx_ie;
        logic rx_ie;
        logic en;
    } ctrl_t;

    // Decoded bus events for one cycle
    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic data_wr;
        logic ctl_wr;
        logic ctl_rd;
    } bus_evt_t;

    function automatic logic flag_rst_val(int idx);
        return (idx == FI_TXE);
    endfunction

    function automatic int stat_bit(int idx);
        case (idx)
            FI_RXF:  return 7;
            FI_TXE:  return 5;
            default: return 4;
        endcase
    endfunction

    function automatic bus_evt_t decode_bus(logic rd, logic wr, logic in_range, reg_sel_e sel);
        bus_evt_t e;
        logic     rd_only;
        rd_only   = rd & ~wr;
        e.stat_rd = rd_only & in_range & (sel == RS_STAT);
        e.data_rd = rd_only & in_range & (sel == RS_DATA);
        e.ctl_rd  = rd_only & in_range & (sel == RS_CTRL);
        e.data_wr = wr & in_range & (sel == RS_DATA);
        e.ctl_wr  = wr & in_range & (sel == RS_CTRL);
        return e;
    endfunction

endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,        // block disabled: hold reset state
    input  logic set_req,     // event that sets the flag
    input  logic observe,     // status read this cycle
    input  logic clr_access,  // the access that completes the handshake
    output logic flag,
    output logic cleared      // handshake completed and flag dropped
);
    logic flag_q;
    logic armed_q;

    assign flag    = flag_q;
    assign cleared = clr_access & armed_q & ~set_req & ~kill;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            flag_q  <= RST_VAL;
            armed_q <= 1'b0;
        end else begin
            if (set_req)
                flag_q <= 1'b1;
            else if (cleared)
                flag_q <= 1'b0;

            if (clr_access)
                armed_q <= 1'b0;           // handshake used up (R10)
            else if (observe && flag_q)
                armed_q <= 1'b1;           // status saw the flag set (R11)
            else if (!flag_q)
                armed_q <= 1'b0;           // flag dropped before access
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_q && !kill && !clr_access |=> flag_q);              // R1
    AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> flag_q);                                      // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_req && !kill |=> flag_q);                             // R10

endmodule

// File: rtl/spi_data_buf.sv
module spi_data_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] rx_in,
    input  logic              accept,
    input  logic [DATA_W-1:0] tx_in,
    output logic [DATA_W-1:0] rx_q,
    output logic [DATA_W-1:0] tx_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
            tx_q <= '0;
        end else begin
            if (capture) rx_q <= rx_in;
            if (accept)  tx_q <= tx_in;
        end
    end
endmodule

// File: rtl/spi_irq_merge.sv
module spi_irq_merge #(
    parameter int NUM_SRC = 3
) (
    input  logic               enable,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] gate,
    output logic               req
);
    assign req = enable & (|(src & gate));
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int DATA_W = 8,   // at least 8: status layout uses bit 7
    parameter int ADDR_W = 3    // at least 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_take,
    input  logic              eng_fault,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              eng_halt,
    output logic              irq
);
    localparam logic [DATA_W-1:0] STAT_RST = DATA_W'(8'h20);

    ctrl_t                 ctrl_q;
    bus_evt_t              evt;
    logic                  in_range;
    reg_sel_e              sel;
    logic [NUM_FLAGS-1:0]  flag;
    logic [NUM_FLAGS-1:0]  set_req;
    logic [NUM_FLAGS-1:0]  clr_acc;
    logic [NUM_FLAGS-1:0]  cleared;
    logic [NUM_FLAGS-1:0]  irq_gate;
    logic [DATA_W-1:0]     status;
    logic [DATA_W-1:0]     rx_q;
    logic                  kill;

    // Bus decode
    assign in_range = ((bus_addr >> 2) == '0);
    assign sel      = reg_sel_e'(bus_addr[1:0]);
    assign evt      = decode_bus(bus_rd, bus_wr, in_range, sel);
    assign kill     = ~ctrl_q.en;
    assign eng_halt = kill;

    // Control register
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (evt.ctl_wr)
            ctrl_q <= ctrl_t'(bus_wdata[CTL_W-1:0]);
    end

    // Flag event routing
    always_comb begin
        set_req          = '0;
        clr_acc          = '0;
        set_req[FI_RXF]  = eng_done;
        set_req[FI_TXE]  = eng_take & ~flag[FI_TXE];
        set_req[FI_MDF]  = eng_fault;
        clr_acc[FI_RXF]  = evt.data_rd;
        clr_acc[FI_TXE]  = evt.data_wr;
        clr_acc[FI_MDF]  = evt.ctl_wr;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        spi_flag_cell #(
            .RST_VAL (flag_rst_val(i))
        ) i_cell (
            .clk        (clk),
            .rst        (rst),
            .kill       (kill),
            .set_req    (set_req[i]),
            .observe    (evt.stat_rd),
            .clr_access (clr_acc[i]),
            .flag       (flag[i]),
            .cleared    (cleared[i])
        );

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            cleared[i] |=> !flag[i]);                              // R4
    end

    // Data registers
    spi_data_buf #(
        .DATA_W (DATA_W)
    ) i_buf (
        .clk     (clk),
        .rst     (rst),
        .capture (eng_done & ~flag[FI_RXF] & ~kill),
        .rx_in   (eng_rx_byte),
        .accept  (cleared[FI_TXE]),
        .tx_in   (bus_wdata),
        .rx_q    (rx_q),
        .tx_q    (tx_byte)
    );

    assign tx_valid = ~flag[FI_TXE];

    // Interrupt merge
    always_comb begin
        irq_gate         = '0;
        irq_gate[FI_RXF] = ctrl_q.rx_ie;
        irq_gate[FI_MDF] = ctrl_q.rx_ie;
        irq_gate[FI_TXE] = ctrl_q.tx_ie;
    end

    spi_irq_merge #(
        .NUM_SRC (NUM_FLAGS)
    ) i_irq (
        .enable (ctrl_q.en),
        .src    (flag),
        .gate   (irq_gate),
        .req    (irq)
    );

    // Status byte and read mux
    always_comb begin
        status = '0;
        for (int i = 0; i < NUM_FLAGS; i++)
            status[stat_bit(i)] = flag[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (evt.ctl_rd)  bus_rdata = DATA_W'(ctrl_q);
        if (evt.stat_rd) bus_rdata = status;
        if (evt.data_rd) bus_rdata = rx_q;
    end

    AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.en) |=> (status == STAT_RST));                // R8
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        eng_halt |-> !irq);                                        // R7
    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
        flag[FI_RXF] && eng_done |=> $stable(rx_q));               // R5
    AST_UNARMED_WRITE: assert property (@(posedge clk) disable iff (rst)
        evt.data_wr && !cleared[FI_TXE] |=> $stable(tx_byte));     // R2
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        eng_take && tx_valid && !kill |=> !tx_valid);              // R3

endmodule

// File: tb/test_spi_flag_ctrl.sv
module test_spi_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       eng_done = 1'b0, eng_take = 1'b0, eng_fault = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic [7:0] tx_byte;
    logic       tx_valid, eng_halt, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_all = 1'b0;

    always #10 clk = ~clk;

    spi_flag_ctrl i_spi_flag_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
        .eng_rx_byte(eng_rx_byte), .eng_take(eng_take), .eng_fault(eng_fault),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .eng_halt(eng_halt), .irq(irq)
    );

    // Bench model state, built from the requirements
    logic       m_rxf, m_txe, m_mf, a_rx, a_tx, a_mf;
    logic [7:0] m_rx, m_tx;
    logic [2:0] m_ctl;

    function automatic logic [7:0] m_status();
        return {m_rxf, 1'b0, m_txe, m_mf, 4'b0};
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0:    return {5'b0, m_ctl};
            3'd1:    return m_status();
            3'd2:    return m_rx;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic m_irq();
        return m_ctl[0] & (((m_rxf | m_mf) & m_ctl[1]) | (m_txe & m_ctl[2]));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_rxf = 0; m_txe = 1; m_mf = 0; a_rx = 0; a_tx = 0; a_mf = 0;
        m_rx = 0; m_tx = 0; m_ctl = 0;
    endtask

    task automatic m_step(input logic rd, input logic wr, input logic [2:0] a,
                          input logic [7:0] wd, input logic dn, input logic [7:0] rb,
                          input logic tk, input logic flt);
        logic rdo, st_rd, d_rd, d_wr, c_wr, en;
        logic n_rxf, n_txe, n_mf, n_arx, n_atx, n_amf;
        rdo   = rd & ~wr;
        st_rd = rdo & (a == 3'd1);
        d_rd  = rdo & (a == 3'd2);
        d_wr  = wr & (a == 3'd2);
        c_wr  = wr & (a == 3'd0);
        en    = m_ctl[0];
        if (!en) begin
            n_rxf = 0; n_txe = 1; n_mf = 0; n_arx = 0; n_atx = 0; n_amf = 0;
        end else begin
            // receive-full
            n_rxf = dn ? 1'b1 : ((d_rd && a_rx) ? 1'b0 : m_rxf);
            n_arx = d_rd ? 1'b0 : ((st_rd && m_rxf) ? 1'b1 : (m_rxf ? a_rx : 1'b0));
            if (dn && !m_rxf) m_rx = rb;
            // transmit-empty
            if (d_wr && a_tx && m_txe) begin
                n_txe = 0; m_tx = wd;
            end else if (tk && !m_txe) n_txe = 1;
            else n_txe = m_txe;
            n_atx = d_wr ? 1'b0 : ((st_rd && m_txe) ? 1'b1 : (m_txe ? a_tx : 1'b0));
            // mode-fault
            n_mf  = flt ? 1'b1 : ((c_wr && a_mf) ? 1'b0 : m_mf);
            n_amf = c_wr ? 1'b0 : ((st_rd && m_mf) ? 1'b1 : (m_mf ? a_mf : 1'b0));
        end
        m_rxf = n_rxf; m_txe = n_txe; m_mf = n_mf;
        a_rx = n_arx; a_tx = n_atx; a_mf = n_amf;
        if (c_wr) m_ctl = wd[2:0];
    endtask

    // One bus/engine cycle: drive at negedge, compare before the next posedge
    task automatic cyc(input logic rd, input logic wr, input logic [2:0] a,
                       input logic [7:0] wd, input logic dn, input logic [7:0] rb,
                       input logic tk, input logic flt, output logic [7:0] obs);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        eng_done = dn; eng_rx_byte = rb; eng_take = tk; eng_fault = flt;
        #5;
        obs = bus_rdata;
        check("R3 tx_valid", tx_valid, !m_txe);
        check("R2 tx_byte", tx_byte, m_tx);
        check("R7 irq", irq, m_irq());
        check("R8 eng_halt", eng_halt, !m_ctl[0]);
        if (rd && !wr) check("R6 R9 read data", bus_rdata, m_read(a));
        m_step(rd, wr, a, wd, dn, rb, tk, flt);
    endtask

    task automatic idle();
        logic [7:0] v;
        cyc(0, 0, 0, 0, 0, 0, 0, 0, v);
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        cyc(1, 0, a, 0, 0, 0, 0, 0, v);
        check(tag, v, exp);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] v;
        cyc(0, 1, a, d, 0, 0, 0, 0, v);
    endtask

    task automatic done_b(input logic [7:0] b);
        logic [7:0] v;
        cyc(0, 0, 0, 0, 1, b, 0, 0, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        bus_rd = 0; bus_wr = 0; eng_done = 0; eng_take = 0; eng_fault = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_reset();
    endtask

    initial begin
        #(200000 * 20);
        if (!done_all) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2718));
        m_reset();
        do_reset();

        // Reset state
        rd_exp(1, 8'h20, "R6 status after reset");
        rd_exp(2, 8'h00, "R9 data after reset");
        rd_exp(0, 8'h00, "R9 control after reset");
        check("R7 irq off at reset", irq, 0);

        // Enable with both interrupt enables
        wr_reg(0, 8'h07);
        idle();
        check("R7 irq from transmit-empty", irq, 1);

        // Unarmed data write is ignored
        wr_reg(2, 8'hA5);
        idle();
        check("R2 unarmed write tx_valid", tx_valid, 0);
        check("R2 unarmed write tx_byte", tx_byte, 8'h00);

        // Armed write is accepted
        rd_exp(1, 8'h20, "R2 status before write");
        wr_reg(2, 8'h3C);
        idle();
        check("R2 accepted tx_valid", tx_valid, 1);
        check("R2 accepted tx_byte", tx_byte, 8'h3C);
        rd_exp(1, 8'h00, "R2 transmit-empty cleared");

        // Engine takes the byte
        cyc(0, 0, 0, 0, 0, 0, 1, 0, v);
        idle();
        check("R3 take empties", tx_valid, 0);
        rd_exp(1, 8'h20, "R3 transmit-empty set again");

        // Receive and clear
        done_b(8'h81);
        rd_exp(1, 8'hA0, "R1 receive-full set");
        rd_exp(2, 8'h81, "R1 received byte");
        rd_exp(1, 8'h20, "R1 receive-full cleared");

        // Overrun keeps the first byte
        done_b(8'h11);
        done_b(8'h22);
        rd_exp(2, 8'h11, "R5 first byte kept");
        rd_exp(1, 8'hA0, "R5 flag still set");

        // Done in the same cycle as the clearing read
        cyc(1, 0, 2, 0, 1, 8'h33, 0, 0, v);
        check("R10 data at collision", v, 8'h11);
        rd_exp(1, 8'hA0, "R10 flag survives collision");
        rd_exp(2, 8'h11, "R10 colliding byte dropped");
        rd_exp(1, 8'h20, "R10 cleared after new handshake");

        // Status read with flag clear does not arm
        done_b(8'h44);
        rd_exp(2, 8'h44, "R11 new byte");
        rd_exp(1, 8'hA0, "R11 no arming from stale status read");
        rd_exp(2, 8'h44, "R11 data again");
        rd_exp(1, 8'h20, "R11 cleared");

        // Mode fault
        wr_reg(0, 8'h03);
        idle();
        check("R7 irq gated off", irq, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, v);
        idle();
        check("R7 irq from mode-fault", irq, 1);
        wr_reg(0, 8'h03);
        rd_exp(1, 8'h30, "R4 fault kept without status read");
        wr_reg(0, 8'h03);
        rd_exp(1, 8'h20, "R4 fault cleared");
        check("R7 irq after fault clear", irq, 0);
        wr_reg(0, 8'h07);

        // Status writes ignored
        wr_reg(1, 8'hFF);
        rd_exp(1, 8'h20, "R6 status write ignored");

        // Disable resets flags
        done_b(8'h55);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, v);
        rd_exp(1, 8'hB0, "R8 flags before disable");
        wr_reg(0, 8'h00);
        idle();
        rd_exp(1, 8'h20, "R8 flags after disable");
        done_b(8'h66);
        rd_exp(1, 8'h20, "R8 done ignored while disabled");
        rd_exp(2, 8'h55, "R8 data kept");
        check("R8 halt", eng_halt, 1);
        check("R8 irq low", irq, 0);

        // Reserved bits and addresses
        wr_reg(0, 8'hFF);
        rd_exp(0, 8'h07, "R9 control reserved bits");
        wr_reg(3, 8'h5A);
        rd_exp(3, 8'h00, "R9 address 3");
        rd_exp(5, 8'h00, "R9 address 5");
        cyc(1, 1, 0, 8'h01, 0, 0, 0, 0, v);
        rd_exp(0, 8'h01, "R9 read and write together acts as write");

        // Constrained random
        do_reset();
        wr_reg(0, 8'h07);
        for (int k = 0; k < 4000; k++) begin
            logic       r, w, dn, tk, fl;
            logic [2:0] a;
            logic [7:0] d;
            int         p;
            p  = $urandom_range(99);
            r  = (p < 45);
            w  = (p >= 40) && (p < 70);
            a  = 3'($urandom_range(4));
            d  = 8'($urandom);
            if (w && a == 0) d[0] = ($urandom_range(19) != 0);
            dn = ($urandom_range(9) == 0);
            tk = ($urandom_range(7) == 0);
            fl = ($urandom_range(39) == 0);
            cyc(r, w, a, d, dn, 8'($urandom), tk, fl, v);
        end
        idle();

        done_all = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule